// File: doc/BRIEF.md
# Audio Serial Transmit Slot Engine

This block turns audio samples written into a single holding register into a one-bit serial stream for a two-slot (left/right) audio link. A separate clock block supplies a one-cycle strobe for every bit period (the point where serial data may change) together with the word-select level. The engine finds slot boundaries from word-select edges, or, when a slot reaches its configured width without an edge, starts the next slot by itself. It shifts each sample out most significant bit first and drives zero in every remaining bit position of the slot.

Configuration inputs select the sample length, including two packed modes that carry two samples in one holding-register word. They also select standard (one-bit delayed) or left-justified timing, mono duplication, a 24-bit slot for 18/20/24-bit samples, and the value sent when no sample is waiting. A loopback select routes the serial output to the receive-side data input.

The framing control is a three-state machine. IDLE waits for the first slot start. DATA drives sample bits. PAD drives zero fill. The transitions are:
- IDLE to DATA on a slot start.
- DATA to PAD after the last sample bit.
- DATA or PAD back to DATA on every later slot start.
- Any state to IDLE while the enable is low.

Top module: `i2s_tx_serializer`

## Requirements
- R1: After reset, sd_o and urun_o are 0 and hold_rdy_o is 1.
- R2: An accepted write (hold_wr_i while hold_rdy_o is 1) drops hold_rdy_o from the next cycle. hold_rdy_o returns to 1 in the cycle after a slot start takes the word. A write while hold_rdy_o is 0 is ignored and the stored word is kept.
- R3: cfg_len_i sets the sample length: 0=32, 1=24, 2=20, 3=18, 4=16, 5=16 packed, 6=8, 7=8 packed bits. An unpacked sample is the low-order bits of the holding word. Its bits go out MSB first from the slot start, and every later position of the slot is 0.
- R4: Word-select is sampled at each bit strobe. With cfg_lj_i=0, a slot's MSB appears at the strobe after the strobe that saw the word-select change. With cfg_lj_i=1, it appears at that same strobe.
- R5: A slot started by a word-select edge is the left slot when word-select is low and the right slot when it is high. The first slot after enable starts on the first strobe that sees word-select low.
- R6: The slot width is 24 positions when cfg_slot24_i=1 and the length code is 1, 2 or 3, and 32 positions otherwise. When a slot reaches its width with no edge-started slot due, the next slot starts at the next strobe and carries the other channel.
- R7: With cfg_mono_i=1, a right slot resends the sample of the preceding left slot and takes nothing from the holding register.
- R8: In packed modes (codes 5 and 7), the left slot takes the word: left = bits 15:0 and right = bits 31:16 for code 5; left = bits 7:0 and right = bits 15:8 for code 7. The right slot then sends the stored half.
- R9: A slot that needs a sample when none is available sends a fill sample and pulses urun_o for one cycle. The fill is 0 when cfg_fill_prev_i=0, and the last sample sent when cfg_fill_prev_i=1.
- R10: rx_sd_o equals sd_o when cfg_loop_i=1 and sd_ext_i when it is 0.
- R11: While en_i is low, sd_o is 0, framing and sample history return to the reset state, and the holding register keeps its content.
- R12: sd_o changes only in the cycle after a bit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Transmit enable |
| cfg_len_i | input | 3 | Sample length code |
| cfg_lj_i | input | 1 | 1 = left-justified timing, 0 = one-bit delayed timing |
| cfg_mono_i | input | 1 | Duplicate left sample into right slot |
| cfg_slot24_i | input | 1 | 24-position slot for 18/20/24-bit samples |
| cfg_fill_prev_i | input | 1 | Underrun fill: 1 = previous sample, 0 = zero |
| cfg_loop_i | input | 1 | Route serial output to receive data |
| hold_wr_i | input | 1 | Holding-register write strobe |
| hold_data_i | input | 32 | Holding-register write data |
| hold_rdy_o | output | 1 | Holding register can accept a word |
| bit_tick_i | input | 1 | One-cycle strobe per bit period |
| ws_i | input | 1 | Word-select level |
| sd_o | output | 1 | Serial data out |
| sd_ext_i | input | 1 | External serial data in |
| rx_sd_o | output | 1 | Serial data toward the receiver |
| urun_o | output | 1 | One-cycle underrun pulse |

## Verification
The hardest situation to reach is a slot that starts by width exhaustion instead of by a word-select edge. It matters most where that start coincides with an edge, or where a packed right slot follows a left slot that underran. The stimulus holds word-select low for hundreds of strobes with a 24-position slot, so the engine alternates channels on its own. Other runs use word-select half-periods equal to the slot width, so both start causes land on the same strobe. Underrun runs switch off the background feeder partway through a packed stream, which leaves the stored right half missing.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

    localparam int unsigned SMP_W = 32;
    localparam int unsigned CNT_W = $clog2(SMP_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PAD  = 2'd2
    } frm_st_e;

    // sample length in bits for each length code
    function automatic logic [CNT_W-1:0] len_of(input logic [2:0] code);
        unique case (code)
            3'd0:       len_of = CNT_W'(32);
            3'd1:       len_of = CNT_W'(24);
            3'd2:       len_of = CNT_W'(20);
            3'd3:       len_of = CNT_W'(18);
            3'd4, 3'd5: len_of = CNT_W'(16);
            default:    len_of = CNT_W'(8);
        endcase
    endfunction

    function automatic logic packed_of(input logic [2:0] code);
        packed_of = (code == 3'd5) || (code == 3'd7);
    endfunction

    function automatic logic [CNT_W-1:0] slotw_of(input logic [2:0] code, input logic s24);
        slotw_of = (s24 && (code inside {3'd1, 3'd2, 3'd3})) ? CNT_W'(24) : CNT_W'(32);
    endfunction

endpackage

// File: rtl/i2stx_hold_buf.sv
module i2stx_hold_buf #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    input  logic         take_i,
    output logic         full_o,
    output logic [W-1:0] data_o
);

    logic         full_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (take_i) full_q <= 1'b0;
            if (wr_i && !full_q) begin
                full_q <= 1'b1;
                data_q <= data_i;
            end
        end
    end

    assign full_o = full_q;
    assign data_o = data_q;

    // R2: a write while full leaves the stored word untouched
    p_wr_full_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_q && wr_i) |=> $stable(data_q));

    // R9: the shifter never takes from an empty register
    p_take_needs_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |-> full_q);

endmodule

// File: rtl/i2stx_frame_ctl.sv
module i2stx_frame_ctl
    import i2stx_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic          ws_i,
    input  logic          lj_i,
    input  logic [CW-1:0] len_i,
    input  logic [CW-1:0] slotw_i,
    output logic          start_o,
    output logic          chan_o,
    output frm_st_e       state_o
);

    frm_st_e       st_q, st_d;
    logic          ws_q, edge_q, ch_q;
    logic [CW-1:0] pos_q;
    logic          ws_edge, start_ws, start_auto;

    always_comb begin
        ws_edge    = ws_i ^ ws_q;
        start_ws   = tick_i && (lj_i ? ws_edge : edge_q);
        start_auto = tick_i && (st_q != ST_IDLE) && (pos_q == slotw_i);
        start_o    = en_i && (start_ws || start_auto);
        chan_o     = start_ws ? (lj_i ? ws_i : ws_q) : ~ch_q;
    end

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start_o) st_d = ST_DATA;
                ST_DATA: begin
                    if (start_o)                                st_d = ST_DATA;
                    else if (tick_i && (pos_q == len_i - 1'b1)) st_d = ST_PAD;
                end
                ST_PAD:  if (start_o) st_d = ST_DATA;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_IDLE;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ws_q   <= 1'b1;
            edge_q <= 1'b0;
            ch_q   <= 1'b0;
            pos_q  <= '0;
        end else if (!en_i) begin
            ws_q   <= 1'b1;
            edge_q <= 1'b0;
            ch_q   <= 1'b0;
            pos_q  <= '0;
        end else if (tick_i) begin
            ws_q   <= ws_i;
            edge_q <= ws_edge;
            if (start_o) begin
                pos_q <= CW'(1);
                ch_q  <= chan_o;
            end else if (st_q != ST_IDLE) begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    assign state_o = st_q;

    // R6: a running slot never counts past its width
    p_pos_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q != ST_IDLE) |-> (pos_q <= slotw_i));

endmodule

// File: rtl/i2stx_shift_unit.sv
module i2stx_shift_unit
    import i2stx_pkg::*;
#(
    parameter int unsigned W  = SMP_W,
    parameter int unsigned CW = CNT_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic         tick_i,
    input  logic         start_i,
    input  logic         chan_i,
    input  logic [2:0]   len_code_i,
    input  logic         mono_i,
    input  logic         fill_prev_i,
    input  logic         hold_full_i,
    input  logic [W-1:0] hold_data_i,
    output logic         take_o,
    output logic         sd_o,
    output logic         urun_o
);

    logic [W-1:0]  sh_q, prev_q, pend_q, lcopy_q;
    logic          pend_v_q, sd_q, urun_q;
    logic [CW-1:0] len;
    logic          pk;
    logic [W-1:0]  mask, lo, hi, fill, smp, aligned;
    logic          miss, need_hold;

    always_comb begin
        len       = len_of(len_code_i);
        pk        = packed_of(len_code_i);
        mask      = ~({W{1'b1}} << len);
        lo        = hold_data_i & mask;
        hi        = (hold_data_i >> len) & mask;
        fill      = fill_prev_i ? prev_q : '0;
        need_hold = start_i && (!chan_i || (!mono_i && !pk));
        take_o    = need_hold && hold_full_i;
        if (chan_i && mono_i) begin
            smp  = lcopy_q;
            miss = 1'b0;
        end else if (chan_i && pk) begin
            smp  = pend_v_q ? pend_q : fill;
            miss = !pend_v_q;
        end else begin
            smp  = hold_full_i ? lo : fill;
            miss = !hold_full_i;
        end
        aligned = smp << (CW'(W) - len);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q     <= '0;
            sd_q     <= 1'b0;
            urun_q   <= 1'b0;
            prev_q   <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            lcopy_q  <= '0;
        end else if (!en_i) begin
            sh_q     <= '0;
            sd_q     <= 1'b0;
            urun_q   <= 1'b0;
            prev_q   <= '0;
            pend_v_q <= 1'b0;
            lcopy_q  <= '0;
        end else begin
            urun_q <= start_i && miss;
            if (tick_i) begin
                if (start_i) begin
                    sd_q   <= aligned[W-1];
                    sh_q   <= aligned << 1;
                    prev_q <= smp;
                    if (!chan_i) begin
                        lcopy_q  <= smp;
                        pend_q   <= hi;
                        pend_v_q <= hold_full_i && pk && !mono_i;
                    end else if (pk && !mono_i) begin
                        pend_v_q <= 1'b0;
                    end
                end else begin
                    sd_q <= sh_q[W-1];
                    sh_q <= sh_q << 1;
                end
            end
        end
    end

    assign sd_o   = sd_q;
    assign urun_o = urun_q;

    // R9: the underrun pulse only follows a bit strobe
    p_urun_on_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        urun_q |-> $past(tick_i));

    // R12: serial data holds between strobes
    p_sd_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(tick_i) && $past(en_i)) |-> $stable(sd_q));

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2stx_pkg::*;
#(
    parameter int unsigned DATA_W = SMP_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [2:0]        cfg_len_i,
    input  logic              cfg_lj_i,
    input  logic              cfg_mono_i,
    input  logic              cfg_slot24_i,
    input  logic              cfg_fill_prev_i,
    input  logic              cfg_loop_i,
    input  logic              hold_wr_i,
    input  logic [DATA_W-1:0] hold_data_i,
    output logic              hold_rdy_o,
    input  logic              bit_tick_i,
    input  logic              ws_i,
    output logic              sd_o,
    input  logic              sd_ext_i,
    output logic              rx_sd_o,
    output logic              urun_o
);

    localparam int unsigned CW = $clog2(DATA_W + 1);

    logic              full, take, start, chan;
    logic [DATA_W-1:0] hold_q;
    frm_st_e           st;

    i2stx_hold_buf #(.W(DATA_W)) u_hold (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (hold_wr_i),
        .data_i (hold_data_i),
        .take_i (take),
        .full_o (full),
        .data_o (hold_q)
    );

    i2stx_frame_ctl #(.CW(CW)) u_frame (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .tick_i  (bit_tick_i),
        .ws_i    (ws_i),
        .lj_i    (cfg_lj_i),
        .len_i   (len_of(cfg_len_i)),
        .slotw_i (slotw_of(cfg_len_i, cfg_slot24_i)),
        .start_o (start),
        .chan_o  (chan),
        .state_o (st)
    );

    i2stx_shift_unit #(.W(DATA_W), .CW(CW)) u_shift (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .tick_i      (bit_tick_i),
        .start_i     (start),
        .chan_i      (chan),
        .len_code_i  (cfg_len_i),
        .mono_i      (cfg_mono_i),
        .fill_prev_i (cfg_fill_prev_i),
        .hold_full_i (full),
        .hold_data_i (hold_q),
        .take_o      (take),
        .sd_o        (sd_o),
        .urun_o      (urun_o)
    );

    assign hold_rdy_o = !full;
    assign rx_sd_o    = cfg_loop_i ? sd_o : sd_ext_i;

    // R3: once a strobe passes in PAD without a new slot, the line is zero
    p_pad_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(st == ST_PAD && bit_tick_i && !start) |-> !sd_o);

endmodule

// File: tb/i2s_tx_serializer_tb_top.sv
module i2s_tx_serializer_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0, en = 1'b0;
    logic [2:0]  len = 3'd0;
    logic        lj = 0, mono = 0, s24 = 0, fp = 0, loopb = 0;
    logic        hold_wr = 0, tick = 0, ws = 0, sd_ext = 0;
    logic [31:0] hold_data = '0;
    logic        hold_rdy, sd, rx_sd, urun;

    i2s_tx_serializer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cfg_len_i(len), .cfg_lj_i(lj),
        .cfg_mono_i(mono), .cfg_slot24_i(s24), .cfg_fill_prev_i(fp), .cfg_loop_i(loopb),
        .hold_wr_i(hold_wr), .hold_data_i(hold_data), .hold_rdy_o(hold_rdy),
        .bit_tick_i(tick), .ws_i(ws), .sd_o(sd), .sd_ext_i(sd_ext),
        .rx_sd_o(rx_sd), .urun_o(urun)
    );

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    feed_on = 0, done = 0;
    logic [31:0] lcg = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int blen(input logic [2:0] c);
        case (c)
            3'd0: return 32;
            3'd1: return 24;
            3'd2: return 20;
            3'd3: return 18;
            3'd4, 3'd5: return 16;
            default: return 8;
        endcase
    endfunction

    // behavioural reference model
    bit          m_full, m_wsq, m_edgeq, m_active, m_ch, m_pendv, m_sd, m_urun;
    logic [31:0] m_hold, m_prev, m_pend, m_lcopy;
    int          m_pos;
    bit          m_q[$];

    always @(posedge clk) begin : model
        bit full_b, edge_s, sws, sau, ch, comp;
        int L, sw;
        logic [31:0] lo, hi, fill, smp;
        full_b = m_full;
        if (!rst_n) begin
            m_full = 0; m_hold = 0; m_wsq = 1; m_edgeq = 0; m_active = 0; m_ch = 0;
            m_pendv = 0; m_pend = 0; m_prev = 0; m_lcopy = 0; m_sd = 0; m_urun = 0;
            m_pos = 0; m_q.delete();
        end else begin
            if (!en) begin
                m_wsq = 1; m_edgeq = 0; m_active = 0; m_ch = 0; m_pos = 0; m_q.delete();
                m_prev = 0; m_pendv = 0; m_lcopy = 0; m_sd = 0; m_urun = 0;
            end else begin
                m_urun = 0;
                if (tick) begin
                    L = blen(len);
                    comp = (len == 3'd5) || (len == 3'd7);
                    sw = (s24 && (len == 3'd1 || len == 3'd2 || len == 3'd3)) ? 24 : 32;
                    edge_s = (ws != m_wsq);
                    sws = lj ? edge_s : m_edgeq;
                    sau = m_active && (m_pos == sw);
                    if (sws || sau) begin
                        ch = sws ? (lj ? ws : m_wsq) : !m_ch;
                        lo = 0; hi = 0;
                        for (int i = 0; i < L; i++) begin
                            lo[i] = m_hold[i];
                            if (L + i < 32) hi[i] = m_hold[L + i];
                        end
                        fill = fp ? m_prev : 32'h0;
                        if (ch && mono) smp = m_lcopy;
                        else if (ch && comp) begin
                            if (m_pendv) smp = m_pend;
                            else begin smp = fill; m_urun = 1; end
                            m_pendv = 0;
                        end else begin
                            if (full_b) begin smp = lo; m_full = 0; end
                            else begin smp = fill; m_urun = 1; end
                            if (!ch) begin m_pend = hi; m_pendv = full_b && comp && !mono; end
                        end
                        m_prev = smp;
                        if (!ch) m_lcopy = smp;
                        m_ch = ch; m_pos = 0; m_active = 1;
                        m_q.delete();
                        for (int i = L - 1; i >= 0; i--) m_q.push_back(smp[i]);
                    end
                    if (m_active) begin
                        m_sd = (m_q.size() > 0) ? m_q.pop_front() : 1'b0;
                        m_pos++;
                    end
                    m_edgeq = edge_s;
                    m_wsq = ws;
                end
            end
            if (hold_wr && !full_b) begin m_full = 1; m_hold = hold_data; end
        end
    end

    // per-clock comparison, away from the edges
    bit last_sd = 0;
    always begin
        @(posedge clk);
        #1;
        if (rst_n && !done) begin
            chk(sd === m_sd, cur_req, "sd_o", sd, m_sd);
            chk(hold_rdy === !m_full, "R2", "hold_rdy_o", hold_rdy, !m_full);
            chk(urun === m_urun, "R9", "urun_o", urun, m_urun);
            chk(rx_sd === (loopb ? m_sd : sd_ext), "R10", "rx_sd_o", rx_sd, loopb ? m_sd : sd_ext);
            if (!tick && en) chk(sd === last_sd, "R12", "sd_o without strobe", sd, last_sd);
        end
        last_sd = sd;
    end

    // background holding-register feeder
    always @(negedge clk) begin
        if (feed_on && rst_n && hold_rdy && !hold_wr) begin
            lcg = lcg * 32'h0019_660D + 32'h3C6E_F35F;
            hold_data <= lcg;
            hold_wr   <= 1'b1;
        end else begin
            hold_wr <= 1'b0;
        end
    end

    task automatic ticks(input int n, input int half);
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            tick   = 1'b1;
            ws     = ((t / half) % 2) == 1;
            sd_ext = 1'($urandom);
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic run(input string req, input logic [2:0] l, input bit j, input bit mo,
                       input bit s, input bit f, input bit lb, input bit feed,
                       input int half, input int n);
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        cur_req = req;
        len = l; lj = j; mono = mo; s24 = s; fp = f; loopb = lb; feed_on = feed;
        repeat (3) @(negedge clk);
        en = 1'b1;
        ticks(n, half);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(sd === 1'b0, "R1", "reset sd_o", sd, 0);
        chk(hold_rdy === 1'b1, "R1", "reset hold_rdy_o", hold_rdy, 1);
        chk(urun === 1'b0, "R1", "reset urun_o", urun, 0);
        @(negedge clk);
        rst_n = 1'b1;
        feed_on = 1;
        repeat (4) @(negedge clk);

        run("R3 R4 R5 32b delayed", 3'd0, 0, 0, 0, 0, 0, 1, 32, 140);
        run("R3 R4 24b left-justified", 3'd1, 1, 0, 0, 0, 0, 1, 32, 140);
        run("R6 20b slot24 delayed", 3'd2, 0, 0, 1, 0, 0, 1, 24, 110);
        run("R6 18b slot24 auto-advance", 3'd3, 1, 0, 1, 0, 0, 1, 1000, 130);
        run("R6 24b slot32 auto-advance", 3'd1, 0, 0, 0, 0, 0, 1, 1000, 100);
        run("R7 16b mono", 3'd4, 0, 1, 0, 0, 0, 1, 16, 100);
        run("R8 16b packed", 3'd5, 1, 0, 0, 0, 0, 1, 16, 100);
        run("R8 8b packed", 3'd7, 0, 0, 0, 0, 0, 1, 8, 70);
        run("R7 R8 8b packed mono", 3'd7, 1, 1, 0, 0, 0, 1, 8, 70);
        run("R9 8b underrun zero fill", 3'd6, 0, 0, 0, 0, 0, 0, 8, 60);
        run("R9 16b underrun previous fill", 3'd4, 1, 0, 0, 1, 0, 1, 16, 20);
        feed_on = 0;
        ticks(60, 16);
        run("R9 R8 packed underrun", 3'd5, 0, 0, 0, 1, 0, 1, 16, 30);
        feed_on = 0;
        ticks(60, 16);
        run("R10 loopback", 3'd1, 1, 0, 0, 0, 1, 1, 32, 80);
        run("R10 external path", 3'd0, 0, 0, 0, 0, 0, 1, 32, 40);

        // R11: drop the enable mid-slot
        begin
            bit rdy_before;
            feed_on = 0;
            repeat (2) @(negedge clk);
            rdy_before = hold_rdy;
            en = 1'b0;
            @(posedge clk);
            #1;
            chk(sd === 1'b0, "R11", "sd_o after disable", sd, 0);
            chk(hold_rdy === rdy_before, "R11", "holding kept", hold_rdy, rdy_before);
        end
        run("R11 restart after disable", 3'd4, 0, 0, 0, 1, 0, 0, 16, 40);

        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule